// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host side of a three-wire synchronous link to a 12-bit serial analog-to-digital converter. A pulse on `start_i` lowers the active-low chip-select, which also wakes the converter from shutdown. The block then toggles a serial clock whose period comes from a divider of the system clock. On each rising serial-clock edge it samples the data line, because the converter changes its data on the falling edge. The first edges of a frame cover the converter's sampling interval. A null bit, expected to be 0, follows them. After that the result arrives most significant bit first.

In checked mode the controller keeps clocking after the last data bit. The converter then repeats the word least significant bit first, without B0. The controller compares that repeat with B1 to B11 of the first copy and flags any difference. At the end of a frame the controller raises chip-select, which powers the converter down. It presents the word with a one-cycle valid strobe and keeps chip-select high for at least a set number of system cycles before the next frame can start.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset `cs_no` is 1, while `sclk_o`, `busy_o`, `valid_o`, `frame_err_o`, `echo_err_o` and `data_o` are all 0.
- R2: A `start_i` pulse while `busy_o` is 0 drives `cs_no` low and `busy_o` high on the following cycle. `busy_o` stays high until the chip-select recovery gap ends. A `start_i` pulse while `busy_o` is 1 is ignored.
- R3: `sclk_o` is low whenever `cs_no` is high. While `cs_no` is low, each high and each low phase of `sclk_o` lasts exactly CLK_DIV system cycles, and the first rising edge comes CLK_DIV cycles after `cs_no` falls.
- R4: With `check_en_i` at 0 when the frame starts, a frame has exactly SMPL_CLKS+1+DATA_W rising edges (15 by default). `cs_no` rises with the falling edge that follows the last rising edge.
- R5: Rising edges are numbered from 1. The line is ignored on edges 1 to SMPL_CLKS, the null bit is sampled on edge SMPL_CLKS+1, and edges SMPL_CLKS+2 to SMPL_CLKS+1+DATA_W give B11 down to B0. The result is `data_o[11]`=B11 through `data_o[0]`=B0.
- R6: `valid_o` is high for exactly one cycle per frame, in the cycle where `cs_no` first reads high again. `data_o`, `frame_err_o` and `echo_err_o` change only with `valid_o` and hold their values until the next one.
- R7: `frame_err_o` reports whether the null bit was sampled as 1.
- R8: With `check_en_i` at 1 when the frame starts, the frame has DATA_W-1 more rising edges (26 in total). These edges carry B1, B2, ... up to B11, in that order. `echo_err_o` is 1 when any of them differs from the matching bit of the first copy. In normal mode `echo_err_o` is 0.
- R9: Between frames `cs_no` stays high for at least CS_GAP system cycles.
- R10: `sdata_i` has no effect while `cs_no` is high or during the sampling interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame when idle |
| check_en_i | input | 1 | Capture and compare the echo, latched at start |
| sdata_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Chip-select, active low; high means shutdown |
| sclk_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | Frame or recovery gap in progress |
| data_o | output | DATA_W | Last conversion result |
| valid_o | output | 1 | One-cycle strobe for a new result |
| frame_err_o | output | 1 | Null bit was read as 1 |
| echo_err_o | output | 1 | Echo did not match the first copy |

## Verification
The assertions assume that `start_i` is sampled on the system clock and that reset is held long enough for every register to clear. They do not depend on `sdata_i`, because the frame length, the clock phases and the chip-select gap come only from the controller's own counters. The bench drives `start_i` and `check_en_i` away from the active edge. A converter model switches `sdata_i` right after each falling serial-clock edge, so the line is stable for a full CLK_DIV phase before it is sampled. While chip-select is high and during the sampling interval, the model drives 1 so that any capture of those values would show in the result.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_GAP
  } seq_st_e;
endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned SMPL_CLKS = 2,
  parameter int unsigned CS_GAP    = 8,
  parameter int unsigned IDX_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             check_en_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             rise_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             chk_o,
  output logic             fin_o
);
  localparam int unsigned N_NORM = SMPL_CLKS + 1 + DATA_W;
  localparam int unsigned N_CHK  = N_NORM + DATA_W - 1;
  localparam int unsigned GW     = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(CS_GAP - 1);

  seq_st_e          st_q;
  logic [IDX_W-1:0] cnt_q;
  logic [GW-1:0]    gap_q;
  logic             sclk_q, cs_q, chk_q;
  logic [IDX_W-1:0] last;

  assign last   = chk_q ? IDX_W'(N_CHK) : IDX_W'(N_NORM);
  assign rise_o = (st_q == ST_RUN) && tick_i && !sclk_q;
  assign fin_o  = (st_q == ST_RUN) && tick_i && sclk_q && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      gap_q  <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      chk_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_RUN;
          cs_q   <= 1'b0;
          sclk_q <= 1'b0;
          chk_q  <= check_en_i;
          cnt_q  <= '0;
        end
        ST_RUN: if (tick_i) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            cnt_q  <= cnt_q + 1'b1;
          end else begin
            sclk_q <= 1'b0;
            if (cnt_q == last) begin
              st_q  <= ST_GAP;
              cs_q  <= 1'b1;
              gap_q <= '0;
            end
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_LAST) st_q <= ST_IDLE;
          else                   gap_q <= gap_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o  = (st_q == ST_RUN);
  assign busy_o = (st_q != ST_IDLE);
  assign cs_no  = cs_q;
  assign sclk_o = sclk_q;
  assign idx_o  = cnt_q;
  assign chk_o  = chk_q;
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned SMPL_CLKS = 2,
  parameter int unsigned IDX_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              sdata_i,
  output logic [DATA_W-1:0] word_o,
  output logic [DATA_W-2:0] echo_o,
  output logic              null_o
);
  localparam logic [IDX_W-1:0] NULL_IDX = IDX_W'(SMPL_CLKS);
  localparam logic [IDX_W-1:0] W_FIRST  = IDX_W'(SMPL_CLKS + 1);
  localparam logic [IDX_W-1:0] W_LAST   = IDX_W'(SMPL_CLKS + DATA_W);
  localparam logic [IDX_W-1:0] E_FIRST  = IDX_W'(SMPL_CLKS + DATA_W + 1);
  localparam logic [IDX_W-1:0] E_LAST   = IDX_W'(SMPL_CLKS + 2 * DATA_W - 1);

  logic [DATA_W-1:0] word_q;
  logic [DATA_W-2:0] echo_q;
  logic              null_q;
  logic              in_word, in_echo;

  assign in_word = (idx_i >= W_FIRST) && (idx_i <= W_LAST);
  assign in_echo = (idx_i >= E_FIRST) && (idx_i <= E_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      echo_q <= '0;
      null_q <= 1'b0;
    end else if (rise_i) begin
      if (idx_i == NULL_IDX) null_q <= sdata_i;
      if (in_word) word_q <= {word_q[DATA_W-2:0], sdata_i};
      // echo arrives B1 first; after DATA_W-1 shifts bit i-1 holds B(i)
      if (in_echo) echo_q <= {sdata_i, echo_q[DATA_W-2:1]};
    end
  end

  assign word_o = word_q;
  assign echo_o = echo_q;
  assign null_o = null_q;
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned SMPL_CLKS = 2,
  parameter int unsigned CLK_DIV   = 4,
  parameter int unsigned CS_GAP    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              check_en_i,
  input  logic              sdata_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              frame_err_o,
  output logic              echo_err_o
);
  localparam int unsigned IDX_W = $clog2(SMPL_CLKS + 2 * DATA_W + 1);

  logic              run, tick, rise, chk, fin;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] word;
  logic [DATA_W-2:0] echo;
  logic              null_bit;

  adc_rd_tick #(.DIV(CLK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run),
    .tick_o (tick)
  );

  adc_rd_seq #(
    .DATA_W    (DATA_W),
    .SMPL_CLKS (SMPL_CLKS),
    .CS_GAP    (CS_GAP),
    .IDX_W     (IDX_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .check_en_i (check_en_i),
    .tick_i     (tick),
    .run_o      (run),
    .cs_no      (cs_no),
    .sclk_o     (sclk_o),
    .busy_o     (busy_o),
    .rise_o     (rise),
    .idx_o      (idx),
    .chk_o      (chk),
    .fin_o      (fin)
  );

  adc_rd_capture #(
    .DATA_W    (DATA_W),
    .SMPL_CLKS (SMPL_CLKS),
    .IDX_W     (IDX_W)
  ) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .idx_i   (idx),
    .sdata_i (sdata_i),
    .word_o  (word),
    .echo_o  (echo),
    .null_o  (null_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o      <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      echo_err_o  <= 1'b0;
    end else begin
      valid_o <= fin;
      if (fin) begin
        data_o      <= word;
        frame_err_o <= null_bit;
        echo_err_o  <= chk && (echo != word[DATA_W-1:1]);
      end
    end
  end
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned SMPL_CLKS = 2,
  parameter int unsigned CS_GAP    = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic sclk_o,
  input logic busy_o,
  input logic valid_o
);
  localparam int unsigned N_NORM = SMPL_CLKS + 1 + DATA_W;
  localparam int unsigned N_CHK  = N_NORM + DATA_W - 1;
  localparam int unsigned RW     = $clog2(N_CHK + 2);
  localparam int unsigned GW     = $clog2(CS_GAP + 2);

  logic [RW-1:0] rises_q;
  logic [GW-1:0] high_q;
  logic          sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rises_q <= '0;
      high_q  <= GW'(CS_GAP);
      sclk_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_o;
      if (cs_no)                  rises_q <= '0;
      else if (sclk_o && !sclk_q) rises_q <= rises_q + 1'b1;
      if (!cs_no)                     high_q <= '0;
      else if (high_q != GW'(CS_GAP)) high_q <= high_q + 1'b1;
    end
  end

  p_sclk_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  p_busy_frame_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o);

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_valid_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cs_no && !$past(cs_no)));

  p_edge_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (rises_q == RW'(N_NORM) || rises_q == RW'(N_CHK)));

  p_cs_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (high_q >= GW'(CS_GAP)));
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
  .DATA_W    (DATA_W),
  .SMPL_CLKS (SMPL_CLKS),
  .CS_GAP    (CS_GAP)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_no   (cs_no),
  .sclk_o  (sclk_o),
  .busy_o  (busy_o),
  .valid_o (valid_o)
);

// File: tb/adc_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_rd_ctrl_tb_top;
  localparam int DW   = 12;
  localparam int SMPL = 2;
  localparam int DIV  = 2;
  localparam int GAP  = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic check_en_i = 1'b0;
  logic sdata_i = 1'b1;
  logic cs_no, sclk_o, busy_o, valid_o, frame_err_o, echo_err_o;
  logic [DW-1:0] data_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [DW-1:0] m_w  = '0;
  logic          m_nb = 1'b0;
  logic [DW-1:0] m_ef = '0;
  int fall_n  = 0;
  bit in_fr   = 0;
  int b_rises = 0;
  int run_len = 0;
  logic prev_sclk = 1'b0;
  int v_sclk = 0;

  always #2 clk_i = ~clk_i;

  adc_rd_ctrl #(.DATA_W(DW), .SMPL_CLKS(SMPL), .CLK_DIV(DIV), .CS_GAP(GAP)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .check_en_i(check_en_i),
    .sdata_i(sdata_i), .cs_no(cs_no), .sclk_o(sclk_o), .busy_o(busy_o),
    .data_o(data_o), .valid_o(valid_o), .frame_err_o(frame_err_o),
    .echo_err_o(echo_err_o)
  );

  function automatic logic stream_bit(int n);
    if (n < SMPL)            return 1'b1;
    if (n == SMPL)           return m_nb;
    if (n <= SMPL + DW)      return m_w[SMPL + DW - n];
    if (n <= SMPL + 2*DW - 1) return m_w[n - SMPL - DW] ^ m_ef[n - SMPL - DW];
    return 1'b0;
  endfunction

  // converter model: new bit after each falling serial-clock edge; 1 while deselected (R10)
  always @(negedge sclk_o or posedge cs_no or negedge cs_no) begin
    if (cs_no !== 1'b0) begin
      sdata_i = 1'b1; fall_n = 0; in_fr = 0;
    end else if (!in_fr) begin
      in_fr = 1; fall_n = 0; sdata_i = stream_bit(0);
    end else begin
      fall_n++; sdata_i = stream_bit(fall_n);
    end
  end

  always @(posedge sclk_o or negedge cs_no) begin
    if (sclk_o === 1'b1) b_rises++;
    else b_rises = 0;
  end

  // serial-clock phase monitor (R3)
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (cs_no) begin
        if (sclk_o !== 1'b0) v_sclk++;
        run_len = 0;
      end else if (sclk_o !== prev_sclk) begin
        if (run_len != DIV) v_sclk++;
        run_len = 1;
      end else run_len++;
      prev_sclk = sclk_o;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy_o && t < 1000) begin @(negedge clk_i); t++; end
  endtask

  task automatic run_frame(logic [DW-1:0] w, bit chk, bit nb, logic [DW-1:0] ef, bit poke);
    int t = 0;
    wait_idle();
    m_w = w; m_nb = nb; m_ef = ef & {{(DW-1){1'b1}}, 1'b0};
    check_en_i = chk; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; check_en_i = ~chk;
    check(!cs_no && busy_o, "R2 start", {cs_no, busy_o}, 2'b01);
    if (poke) begin
      repeat (7) @(negedge clk_i);
      start_i = 1'b1; check_en_i = ~chk;   // ignored while busy
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (!valid_o && t < 1000) begin @(negedge clk_i); t++; end
    check(valid_o, "R6 valid seen", valid_o, 1);
    check(data_o == w, "R5 data", data_o, w);
    check(frame_err_o == nb, "R7 null", frame_err_o, nb);
    check(echo_err_o == (chk && m_ef != 0), "R8 echo", echo_err_o, (chk && m_ef != 0));
    check(b_rises == (chk ? SMPL + 2*DW : SMPL + 1 + DW), "R4 R8 edge count",
          b_rises, chk ? SMPL + 2*DW : SMPL + 1 + DW);
    check(cs_no == 1'b1, "R6 cs with valid", cs_no, 1);
    @(negedge clk_i);
    check(!valid_o, "R6 single pulse", valid_o, 0);
  endtask

  // watchdog
  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    int hi;
    repeat (3) @(negedge clk_i);
    check(cs_no && !sclk_o && !busy_o && !valid_o, "R1 controls", {cs_no, sclk_o, busy_o, valid_o}, 4'b1000);
    check(data_o == 0 && !frame_err_o && !echo_err_o, "R1 results", data_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(cs_no && !busy_o, "R1 after release", {cs_no, busy_o}, 2'b10);

    // sweep, both modes (R4 R5 R8)
    for (int k = 0; k < 64; k++) run_frame(DW'(k * 65 + 7), 1'b0, 1'b0, '0, 1'b0);
    for (int k = 0; k < 64; k++) run_frame(DW'(k * 97 + 3), 1'b1, 1'b0, '0, 1'b0);
    for (int b = 0; b < DW; b++) run_frame(DW'(1) << b, 1'b1, 1'b0, '0, 1'b0);
    run_frame('1, 1'b0, 1'b0, '0, 1'b0);
    run_frame('0, 1'b1, 1'b0, '0, 1'b0);
    run_frame(12'hAAA, 1'b1, 1'b0, '0, 1'b0);
    run_frame(12'h555, 1'b0, 1'b0, '0, 1'b0);
    // echo corruption on every echo position (R8)
    for (int b = 1; b < DW; b++) run_frame(12'hA5C, 1'b1, 1'b0, DW'(1) << b, 1'b0);
    // corrupted echo ignored in normal mode (R8)
    run_frame(12'h3C3, 1'b0, 1'b0, 12'h002, 1'b0);
    // null bit set (R7)
    run_frame(12'h123, 1'b0, 1'b1, '0, 1'b0);
    run_frame(12'hFED, 1'b1, 1'b1, '0, 1'b0);
    run_frame(12'h456, 1'b0, 1'b0, '0, 1'b0);
    // start during frame ignored (R2)
    run_frame(12'h9B1, 1'b0, 1'b0, '0, 1'b1);
    run_frame(12'h2E4, 1'b1, 1'b0, '0, 1'b1);

    // hold between strobes (R6), input ignored while deselected (R10)
    held = data_o;
    for (int i = 0; i < 20; i++) begin sdata_i = i[0]; @(negedge clk_i); end
    check(data_o == held && !valid_o, "R6 R10 hold", data_o, held);

    // recovery gap with start held high (R9)
    run_frame(12'h777, 1'b0, 1'b0, '0, 1'b0);
    start_i = 1'b1; hi = 1;
    while (cs_no && hi < 100) begin @(negedge clk_i); if (cs_no) hi++; end
    start_i = 1'b0;
    check(hi >= GAP && hi <= GAP + 2, "R9 gap", hi, GAP + 1);
    check(busy_o, "R2 busy in frame", busy_o, 1);
    wait_idle();
    check(!busy_o && cs_no, "R2 idle after", {busy_o, cs_no}, 2'b01);

    check(v_sclk == 0, "R3 serial clock phases", v_sclk, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule